// File: doc/BRIEF.md
# Wormhole Mesh Router Input Port

This block is one of the five input ports of a wormhole-switched router placed in a two-dimensional mesh. A sender on the upstream side, either a neighbouring router or the local resource, hands over 32-bit flits one at a time through a request/acknowledge pair. The port keeps the flits in a three-entry queue and reports its free slots back to the sender as a credit count. Flits marked idle are acknowledged but never stored.

The flit at the head of the queue is offered to the switch side together with a one-hot request that names one of five outputs. The first flit of each packet chooses that output by dimension-ordered routing: X is resolved first, then Y. The router's own coordinates arrive on input pins. The choice is kept for every flit that follows, until the end-of-packet flit has left. A single-flit packet is routed and released alone. A flit leaves the queue only in a cycle where the output it requests grants this port.

Top module: `mesh_in_port`

## Requirements
- R1: While synchronous reset is high, and on the cycle after it is released, the queue is empty. `up_credit` reads 3, `up_ack` is 0 and `sw_req` is 0.
- R2: The flit kind sits in bits [1:0]: 00 idle, 01 end of packet, 10 body/head, 11 single-flit packet. An idle flit is acknowledged, but it does not change `up_credit` and does not appear on `sw_req`.
- R3: `up_credit` always equals 3 minus the number of stored flits. When all three slots are full, a pending request is not acknowledged and its flit is not stored until a slot frees.
- R4: The destination x is taken from bits [3:2] and the destination y from bits [5:4]. The route is West 00010 if dest x < own x, and East 00100 if dest x > own x. With equal x, it is South 01000 if dest y < own y, North 10000 if dest y > own y, and Local 00001 if both coordinates match.
- R5: The first flit of a packet fixes the route. Later flits use that stored route whatever bits [5:2] hold. The stored route is dropped once a flit of kind 01 has been released.
- R6: A flit of kind 11 is routed from its own fields and released on its own. The flit after it is routed afresh.
- R7: A stored flit is released, and `sw_req`/`sw_flit` move on, only in a cycle where `sw_grant` has the bit that `sw_req` asserts. Grant bits for other outputs have no effect.
- R8: `up_ack` rises in the cycle after a flit is captured while `up_req` is high. It falls in the cycle after `up_req` is seen low.
- R9: A capture and a release in the same cycle are both carried out, and the stored count stays the same.
- R10: Flits leave in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| own_x | input | 2 | This router's column |
| own_y | input | 2 | This router's row |
| up_req | input | 1 | Upstream flit request |
| up_flit | input | 32 | Upstream flit data |
| up_ack | output | 1 | Acknowledge to upstream |
| up_credit | output | 3 | Free queue slots |
| sw_req | output | 5 | One-hot output request {N,S,E,W,L} |
| sw_flit | output | 32 | Flit at the head of the queue |
| sw_grant | input | 5 | Per-output grant for this port |

## Verification
A new flit can be captured from upstream in the same clock edge that the head flit is released to the switch. The count and credit must then stay where they were. The bench brings this about by filling two slots, then raising the upstream request and the matching grant on the same falling edge. It judges the result by the credit, the acknowledge and the order in which the flits later drain. A second collision is a request that arrives while the queue is full: the bench checks that the acknowledge is held back, and that it follows only after one release has freed a slot.

// File: rtl/mip_pkg.sv
package mip_pkg;

   typedef enum logic [1:0] {
      FK_IDLE = 2'b00,
      FK_END  = 2'b01,
      FK_BODY = 2'b10,
      FK_FULL = 2'b11
   } flit_kind_e;

   localparam int NDIR = 5;

   localparam logic [NDIR-1:0] DIR_LOCAL = 5'b00001;
   localparam logic [NDIR-1:0] DIR_WEST  = 5'b00010;
   localparam logic [NDIR-1:0] DIR_EAST  = 5'b00100;
   localparam logic [NDIR-1:0] DIR_SOUTH = 5'b01000;
   localparam logic [NDIR-1:0] DIR_NORTH = 5'b10000;

   localparam int KIND_W = 2;

endpackage

// File: rtl/mip_flit_fifo.sv
module mip_flit_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 3,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [W-1:0]     wr_data,
   input  logic             rd_en,
   output logic [W-1:0]     rd_data,
   output logic             empty,
   output logic             full,
   output logic [CNT_W-1:0] count
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

   logic [W-1:0]     slot_q [DEPTH];
   logic [PTR_W-1:0] wr_ptr_q;
   logic [PTR_W-1:0] rd_ptr_q;
   logic [CNT_W-1:0] cnt_q;

   function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
      return (p == LAST) ? '0 : p + PTR_W'(1);
   endfunction

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         always_ff @(posedge clk) begin
            if (wr_en && (wr_ptr_q == PTR_W'(i))) begin
               slot_q[i] <= wr_data;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (wr_en) begin
            wr_ptr_q <= ptr_next(wr_ptr_q);
         end
         if (rd_en) begin
            rd_ptr_q <= ptr_next(rd_ptr_q);
         end
         case ({wr_en, rd_en})
            2'b10:   cnt_q <= cnt_q + CNT_W'(1);
            2'b01:   cnt_q <= cnt_q - CNT_W'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign rd_data = slot_q[rd_ptr_q];
   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CNT_MAX);
   assign count   = cnt_q;

endmodule

// File: rtl/mip_xy_route.sv
module mip_xy_route
   import mip_pkg::*;
#(
   parameter int COORD_W = 2
) (
   input  logic [COORD_W-1:0] dst_x,
   input  logic [COORD_W-1:0] dst_y,
   input  logic [COORD_W-1:0] here_x,
   input  logic [COORD_W-1:0] here_y,
   output logic [NDIR-1:0]    dir
);

   always_comb begin
      if (dst_x < here_x) begin
         dir = DIR_WEST;
      end else if (dst_x > here_x) begin
         dir = DIR_EAST;
      end else if (dst_y < here_y) begin
         dir = DIR_SOUTH;
      end else if (dst_y > here_y) begin
         dir = DIR_NORTH;
      end else begin
         dir = DIR_LOCAL;
      end
   end

endmodule

// File: rtl/mip_route_ctrl.sv
module mip_route_ctrl
   import mip_pkg::*;
#(
   parameter int COORD_W = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               head_valid,
   input  logic [KIND_W-1:0]  head_kind,
   input  logic [COORD_W-1:0] head_dx,
   input  logic [COORD_W-1:0] head_dy,
   input  logic [COORD_W-1:0] own_x,
   input  logic [COORD_W-1:0] own_y,
   input  logic [NDIR-1:0]    grant,
   output logic [NDIR-1:0]    req,
   output logic               release_flit
);

   logic [NDIR-1:0] fresh_dir;
   logic [NDIR-1:0] held_dir_q;
   logic            held_q;
   logic [NDIR-1:0] cur_dir;
   flit_kind_e      kind;
   logic            closes_pkt;

   mip_xy_route #(.COORD_W(COORD_W)) u_xy (
      .dst_x  (head_dx),
      .dst_y  (head_dy),
      .here_x (own_x),
      .here_y (own_y),
      .dir    (fresh_dir)
   );

   assign kind         = flit_kind_e'(head_kind);
   assign closes_pkt   = (kind == FK_END) || (kind == FK_FULL);
   assign cur_dir      = held_q ? held_dir_q : fresh_dir;
   assign req          = head_valid ? cur_dir : '0;
   assign release_flit = |(req & grant);

   always_ff @(posedge clk) begin
      if (rst) begin
         held_q     <= 1'b0;
         held_dir_q <= '0;
      end else if (release_flit) begin
         if (closes_pkt) begin
            held_q <= 1'b0;
         end else if (!held_q) begin
            held_q     <= 1'b1;
            held_dir_q <= fresh_dir;
         end
      end
   end

endmodule

// File: rtl/mesh_in_port.sv
module mesh_in_port
   import mip_pkg::*;
#(
   parameter int FLIT_W  = 32,
   parameter int DEPTH   = 3,
   parameter int COORD_W = 2,
   parameter int CRED_W  = 3
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [COORD_W-1:0] own_x,
   input  logic [COORD_W-1:0] own_y,
   input  logic               up_req,
   input  logic [FLIT_W-1:0]  up_flit,
   output logic               up_ack,
   output logic [CRED_W-1:0]  up_credit,
   output logic [4:0]         sw_req,
   output logic [FLIT_W-1:0]  sw_flit,
   input  logic [4:0]         sw_grant
);

   localparam int CNT_W  = $clog2(DEPTH + 1);
   localparam int DX_LSB = KIND_W;
   localparam int DY_LSB = KIND_W + COORD_W;

   generate
      if (DEPTH < 1) begin : g_bad_depth
         initial $error("mesh_in_port: DEPTH must be at least 1");
      end
      if (FLIT_W < KIND_W + 2 * COORD_W) begin : g_bad_width
         initial $error("mesh_in_port: FLIT_W too small for kind and coordinates");
      end
      if (CRED_W < CNT_W) begin : g_bad_cred
         initial $error("mesh_in_port: CRED_W cannot hold DEPTH");
      end
   endgenerate

   logic              ack_q;
   logic              take;
   logic              wr_en;
   logic              rd_en;
   logic              q_empty;
   logic              q_full;
   logic [CNT_W-1:0]  q_count;
   logic [FLIT_W-1:0] head;
   flit_kind_e        in_kind;

   assign in_kind = flit_kind_e'(up_flit[KIND_W-1:0]);
   assign take    = up_req && !ack_q && !q_full;
   assign wr_en   = take && (in_kind != FK_IDLE);

   always_ff @(posedge clk) begin
      if (rst) begin
         ack_q <= 1'b0;
      end else if (ack_q && !up_req) begin
         ack_q <= 1'b0;
      end else if (take) begin
         ack_q <= 1'b1;
      end
   end

   mip_flit_fifo #(
      .W     (FLIT_W),
      .DEPTH (DEPTH),
      .CNT_W (CNT_W)
   ) u_q (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_data (up_flit),
      .rd_en   (rd_en),
      .rd_data (head),
      .empty   (q_empty),
      .full    (q_full),
      .count   (q_count)
   );

   mip_route_ctrl #(.COORD_W(COORD_W)) u_rt (
      .clk          (clk),
      .rst          (rst),
      .head_valid   (!q_empty),
      .head_kind    (head[KIND_W-1:0]),
      .head_dx      (head[DX_LSB +: COORD_W]),
      .head_dy      (head[DY_LSB +: COORD_W]),
      .own_x        (own_x),
      .own_y        (own_y),
      .grant        (sw_grant),
      .req          (sw_req),
      .release_flit (rd_en)
   );

   assign up_ack    = ack_q;
   assign up_credit = CRED_W'(DEPTH) - CRED_W'(q_count);
   assign sw_flit   = head;

endmodule

// File: rtl/mesh_in_port_chk.sv
module mesh_in_port_chk #(
   parameter int FLIT_W = 32,
   parameter int DEPTH  = 3,
   parameter int CRED_W = 3
) (
   input logic              clk,
   input logic              rst,
   input logic              up_req,
   input logic              up_ack,
   input logic [CRED_W-1:0] up_credit,
   input logic [4:0]        sw_req,
   input logic [FLIT_W-1:0] sw_flit,
   input logic [4:0]        sw_grant
);

   AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (rst)
      up_credit <= CRED_W'(DEPTH)); // R3

   AST_NO_ACK_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
      (up_credit == '0 && !up_ack) |=> !up_ack); // R3

   AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(sw_req)); // R4

   AST_HOLD_UNGRANTED: assert property (@(posedge clk) disable iff (rst)
      (sw_req != '0 && (sw_req & sw_grant) == '0)
      |=> (sw_req == $past(sw_req) && sw_flit == $past(sw_flit))); // R7

   AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
      (up_ack && !up_req) |=> !up_ack); // R8

   AST_CREDIT_STEP: assert property (@(posedge clk) disable iff (rst)
      (up_credit == $past(up_credit)) || (up_credit == $past(up_credit) + 1'b1)
      || (up_credit + 1'b1 == $past(up_credit))); // R9

endmodule

bind mesh_in_port mesh_in_port_chk #(
   .FLIT_W (FLIT_W),
   .DEPTH  (DEPTH),
   .CRED_W (CRED_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .up_req    (up_req),
   .up_ack    (up_ack),
   .up_credit (up_credit),
   .sw_req    (sw_req),
   .sw_flit   (sw_flit),
   .sw_grant  (sw_grant)
);

// File: tb/test_mesh_in_port.sv
module test_mesh_in_port;

   localparam logic [4:0] L = 5'b00001;
   localparam logic [4:0] WS = 5'b00010;
   localparam logic [4:0] E = 5'b00100;
   localparam logic [4:0] S = 5'b01000;
   localparam logic [4:0] N = 5'b10000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [1:0]  own_x = 2'd1;
   logic [1:0]  own_y = 2'd2;
   logic        up_req = 1'b0;
   logic [31:0] up_flit = '0;
   logic        up_ack;
   logic [2:0]  up_credit;
   logic [4:0]  sw_req;
   logic [31:0] sw_flit;
   logic [4:0]  sw_grant = '0;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   mesh_in_port i_mesh_in_port (
      .clk       (clk),
      .rst       (rst),
      .own_x     (own_x),
      .own_y     (own_y),
      .up_req    (up_req),
      .up_flit   (up_flit),
      .up_ack    (up_ack),
      .up_credit (up_credit),
      .sw_req    (sw_req),
      .sw_flit   (sw_flit),
      .sw_grant  (sw_grant)
   );

   function automatic logic [31:0] mk(input logic [1:0] kind, input logic [1:0] dx,
                                      input logic [1:0] dy, input logic [25:0] pay);
      return {pay, dy, dx, kind};
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic send(input logic [31:0] f);
      @(negedge clk);
      up_req  = 1'b1;
      up_flit = f;
      for (int i = 0; i < 50 && !up_ack; i++) @(negedge clk);
      chk("R8", "ack after capture", 32'(up_ack), 32'd1);
      up_req = 1'b0;
      @(negedge clk);
      chk("R8", "ack after req low", 32'(up_ack), 32'd0);
   endtask

   task automatic take(input string req, input logic [4:0] dir, input logic [31:0] f);
      chk(req, "sw_req", 32'(sw_req), 32'(dir));
      chk(req, "sw_flit", sw_flit, f);
      sw_grant = dir;
      @(negedge clk);
      sw_grant = '0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1", "credit in reset", 32'(up_credit), 32'd3);
      chk("R1", "ack in reset", 32'(up_ack), 32'd0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1", "credit", 32'(up_credit), 32'd3);
      chk("R1", "sw_req", 32'(sw_req), 32'd0);
   endtask

   task automatic t_idle();
      send(mk(2'b00, 2'd3, 2'd3, 26'h1));
      chk("R2", "credit after idle", 32'(up_credit), 32'd3);
      chk("R2", "sw_req after idle", 32'(sw_req), 32'd0);
   endtask

   task automatic t_routes();
      logic [31:0] f;
      f = mk(2'b11, 2'd0, 2'd3, 26'h10); send(f);
      chk("R3", "credit one stored", 32'(up_credit), 32'd2);
      take("R4", WS, f);
      f = mk(2'b11, 2'd3, 2'd0, 26'h11); send(f); take("R4", E, f);
      f = mk(2'b11, 2'd1, 2'd0, 26'h12); send(f); take("R4", S, f);
      f = mk(2'b11, 2'd1, 2'd3, 26'h13); send(f); take("R6", N, f);
      f = mk(2'b11, 2'd1, 2'd2, 26'h14); send(f); take("R6", L, f);
      chk("R3", "credit drained", 32'(up_credit), 32'd3);
   endtask

   task automatic t_grant();
      logic [31:0] f;
      f = mk(2'b11, 2'd2, 2'd2, 26'h20);
      send(f);
      sw_grant = 5'b11011;
      repeat (3) @(negedge clk);
      sw_grant = '0;
      chk("R7", "req kept under foreign grant", 32'(sw_req), 32'(E));
      chk("R7", "flit kept", sw_flit, f);
      chk("R7", "credit kept", 32'(up_credit), 32'd2);
      take("R7", E, f);
      chk("R7", "released", 32'(up_credit), 32'd3);
   endtask

   task automatic t_wormhole();
      logic [31:0] h, b, e, f;
      h = mk(2'b10, 2'd0, 2'd2, 26'h30);
      b = mk(2'b10, 2'd3, 2'd3, 26'h31);
      e = mk(2'b01, 2'd1, 2'd2, 26'h32);
      send(h); send(b); send(e);
      chk("R3", "credit full", 32'(up_credit), 32'd0);
      take("R5", WS, h);
      take("R5", WS, b);
      take("R10", WS, e);
      chk("R5", "empty after end", 32'(sw_req), 32'd0);
      f = mk(2'b11, 2'd1, 2'd3, 26'h33);
      send(f);
      take("R5", N, f);
   endtask

   task automatic t_full();
      logic [31:0] a, b, c, d;
      a = mk(2'b11, 2'd2, 2'd0, 26'h40);
      b = mk(2'b11, 2'd2, 2'd0, 26'h41);
      c = mk(2'b11, 2'd2, 2'd0, 26'h42);
      d = mk(2'b11, 2'd2, 2'd0, 26'h43);
      send(a); send(b); send(c);
      @(negedge clk);
      up_req  = 1'b1;
      up_flit = d;
      repeat (4) @(negedge clk);
      chk("R3", "no ack while full", 32'(up_ack), 32'd0);
      chk("R3", "credit zero", 32'(up_credit), 32'd0);
      take("R10", E, a);
      for (int i = 0; i < 10 && !up_ack; i++) @(negedge clk);
      chk("R3", "ack once slot free", 32'(up_ack), 32'd1);
      up_req = 1'b0;
      @(negedge clk);
      take("R10", E, b);
      take("R10", E, c);
      take("R3", E, d);
      chk("R3", "credit back", 32'(up_credit), 32'd3);
   endtask

   task automatic t_same_cycle();
      logic [31:0] a, b, c;
      a = mk(2'b11, 2'd3, 2'd1, 26'h50);
      b = mk(2'b11, 2'd3, 2'd1, 26'h51);
      c = mk(2'b11, 2'd3, 2'd1, 26'h52);
      send(a); send(b);
      chk("R9", "credit before", 32'(up_credit), 32'd1);
      @(negedge clk);
      up_req   = 1'b1;
      up_flit  = c;
      sw_grant = E;
      @(negedge clk);
      sw_grant = '0;
      chk("R9", "ack on shared edge", 32'(up_ack), 32'd1);
      chk("R9", "credit unchanged", 32'(up_credit), 32'd1);
      up_req = 1'b0;
      @(negedge clk);
      take("R9", E, b);
      take("R9", E, c);
      chk("R9", "credit drained", 32'(up_credit), 32'd3);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      t_idle();
      t_routes();
      t_grant();
      t_wormhole();
      t_full();
      t_same_cycle();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule